// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the time of day from a 32.768 kHz reference clock. A divide-by-128 prescaler produces a 256 Hz tick. The tick advances an 8-bit binary fraction of a second. Each time the fraction rolls over, a 32-bit seconds count goes up by one. Software reaches the block through a small word-addressed register port on the same clock, using single-cycle read and write strobes.

Reading the seconds register captures the fraction at that same moment. A later fraction read therefore pairs coherently with the seconds value that was read. An alarm compares the time with a programmed seconds and fraction target once per fraction tick. On a match it sets a sticky flag. Writing the seconds target locks the alarm out until the fraction target is written again. This means software cannot get a false match between the two writes.

Top module: `tod_timer`

## Requirements
- R1: A tick occurs once every 128 clock cycles, counted from power-on reset release. Each tick adds one to the fraction counter, modulo 256.
- R2: When a tick moves the fraction from 0xFF to 0x00, the seconds counter increments, modulo 2^32. It does not increment in a cycle where seconds or fraction is being written.
- R3: A read of seconds (address 1) returns the live seconds and copies the current fraction into a snapshot. Reads of the fraction (address 2) return the snapshot in bits 31:24, with bits 23:0 at zero. Repeated fraction reads give the same value until seconds is read again.
- R4: A write to seconds (address 1) loads seconds with the write data and clears the fraction to zero. This write wins over a tick in the same cycle.
- R5: A write to the fraction (address 2) sets all eight fraction bits to one, whatever the write data. This write wins over a tick in the same cycle.
- R6: Holding the functional reset `rst_n` low clears only the control bits (enable and status). The fraction, seconds, snapshot and alarm target registers keep their values and keep counting.
- R7: Power-on reset `por_n` sets every register to zero, including the prescaler, counters, snapshot and alarm targets.
- R8: The control register is at address 0. Bit 0 is the alarm enable and bit 1 is the alarm status. With the enable set and no lockout, a tick in a cycle where seconds equals the seconds target (address 3) and fraction equals the fraction target (address 4, bits 31:24) sets the status. The output `alarm_flag` mirrors the status.
- R9: Writing the control register with bit 1 at one clears the status. Writing bit 1 at zero leaves it unchanged. A match in the same cycle takes priority over the clear.
- R10: A write to the seconds target blocks alarm matches until the fraction target is written afterwards.
- R11: With the enable bit clear, the status is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock; also clocks the register port |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| rst_n | input | 1 | Active-low synchronous functional reset (control bits only) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a seconds read takes the snapshot) |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The hardest condition to reach is a lockout that hides a real match. The stimulus has to write the seconds target, let the fraction run past the intended fraction target, and then confirm that no flag appears. It then has to rewind the time by writing seconds again and write only the fraction target, so that the next match does fire. Rollover of the 32-bit seconds count also needs care, because a full second would take 32768 cycles. The stimulus reaches it quickly by loading 0xFFFFFFFF and forcing the fraction to 0xFF, so the very next tick wraps both counters. A behavioural model of the time, snapshot and alarm follows every clock cycle. It judges each read and the flag in every cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_SEC   = 3'd1;
   localparam logic [ADDR_W-1:0] A_FRAC  = 3'd2;
   localparam logic [ADDR_W-1:0] A_ASEC  = 3'd3;
   localparam logic [ADDR_W-1:0] A_AFRAC = 3'd4;
   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_ST_BIT = 1;
endpackage

// File: rtl/tod_prescale.sv
module tod_prescale #(
   parameter int DIV_LOG2 = 7
) (
   input  logic clk,
   input  logic por_n,
   output logic tick
);
   generate
      if (DIV_LOG2 == 0) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_LOG2-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign tick = &cnt_q;
      end
   endgenerate
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
   parameter int FRAC_W = 8,
   parameter int SEC_W  = 32
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick,
   input  logic             wr_sec,
   input  logic             wr_frac,
   input  logic [SEC_W-1:0] sec_wd,
   output logic [FRAC_W-1:0] frac_q,
   output logic [SEC_W-1:0]  sec_q
);
   logic roll;
   assign roll = tick & (&frac_q) & ~wr_frac;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         frac_q <= '0;
         sec_q  <= '0;
      end else if (wr_sec) begin
         frac_q <= '0;
         sec_q  <= sec_wd;
      end else begin
         if (wr_frac)   frac_q <= '1;
         else if (tick) frac_q <= frac_q + 1'b1;
         if (roll)      sec_q  <= sec_q + 1'b1;
      end
   end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
   parameter int FRAC_W = 8,
   parameter int SEC_W  = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [FRAC_W-1:0] frac,
   input  logic [SEC_W-1:0]  sec,
   input  logic              wr_ctrl,
   input  logic              en_wd,
   input  logic              clr_wd,
   input  logic              wr_asec,
   input  logic [SEC_W-1:0]  asec_wd,
   input  logic              wr_afrac,
   input  logic [FRAC_W-1:0] afrac_wd,
   output logic              en_q,
   output logic              st_q,
   output logic              lock_q,
   output logic [SEC_W-1:0]  asec_q,
   output logic [FRAC_W-1:0] afrac_q
);
   logic hit;
   assign hit = tick & en_q & ~lock_q & (sec == asec_q) & (frac == afrac_q);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         asec_q  <= '0;
         afrac_q <= '0;
         lock_q  <= 1'b0;
      end else begin
         if (wr_asec) begin
            asec_q <= asec_wd;
            lock_q <= 1'b1;
         end
         if (wr_afrac) begin
            afrac_q <= afrac_wd;
            lock_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q <= 1'b0;
         st_q <= 1'b0;
      end else if (!rst_n) begin
         en_q <= 1'b0;
         st_q <= 1'b0;
      end else begin
         st_q <= hit | (st_q & ~(wr_ctrl & clr_wd));
         if (wr_ctrl) en_q <= en_wd;
      end
   end
endmodule

// File: rtl/tod_timer.sv
module tod_timer
   import tod_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int FRAC_W   = 8,
   parameter int DIV_LOG2 = 7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              alarm_flag
);
   localparam int SEC_W    = DATA_W;
   localparam int FRAC_LSB = DATA_W - FRAC_W;

   generate
      if (FRAC_W < 1 || FRAC_W > DATA_W) begin : g_bad_frac
         $error("tod_timer: FRAC_W must lie in 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("tod_timer: DATA_W must hold the control bits");
      end
   endgenerate

   logic              tick;
   logic              wr_ctrl, wr_sec, wr_frac, wr_asec, wr_afrac, rd_sec;
   logic [FRAC_W-1:0] frac, snap_q, afrac;
   logic [SEC_W-1:0]  sec, asec;
   logic              en, st, lock;
   logic [FRAC_W-1:0] wd_frac;

   assign wr_ctrl  = reg_wr & (reg_addr == A_CTRL);
   assign wr_sec   = reg_wr & (reg_addr == A_SEC);
   assign wr_frac  = reg_wr & (reg_addr == A_FRAC);
   assign wr_asec  = reg_wr & (reg_addr == A_ASEC);
   assign wr_afrac = reg_wr & (reg_addr == A_AFRAC);
   assign rd_sec   = reg_rd & (reg_addr == A_SEC);
   assign wd_frac  = reg_wdata[FRAC_LSB +: FRAC_W];

   tod_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk(clk), .por_n(por_n), .tick(tick)
   );

   tod_counter #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_cnt (
      .clk(clk), .por_n(por_n), .tick(tick),
      .wr_sec(wr_sec), .wr_frac(wr_frac), .sec_wd(reg_wdata),
      .frac_q(frac), .sec_q(sec)
   );

   tod_alarm #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_alm (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
      .frac(frac), .sec(sec),
      .wr_ctrl(wr_ctrl), .en_wd(reg_wdata[CTRL_EN_BIT]), .clr_wd(reg_wdata[CTRL_ST_BIT]),
      .wr_asec(wr_asec), .asec_wd(reg_wdata),
      .wr_afrac(wr_afrac), .afrac_wd(wd_frac),
      .en_q(en), .st_q(st), .lock_q(lock), .asec_q(asec), .afrac_q(afrac)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      snap_q <= '0;
      else if (rd_sec) snap_q <= frac;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[CTRL_EN_BIT] = en;
            reg_rdata[CTRL_ST_BIT] = st;
         end
         A_SEC:   reg_rdata = sec;
         A_FRAC:  reg_rdata[FRAC_LSB +: FRAC_W] = snap_q;
         A_ASEC:  reg_rdata = asec;
         A_AFRAC: reg_rdata[FRAC_LSB +: FRAC_W] = afrac;
         default: reg_rdata = '0;
      endcase
   end

   assign alarm_flag = st;
endmodule

// File: rtl/tod_timer_chk.sv
module tod_timer_chk #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic              tick,
   input logic              wr_sec,
   input logic              wr_frac,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [FRAC_W-1:0] frac,
   input logic [DATA_W-1:0] sec,
   input logic              lock,
   input logic              en,
   input logic              st
);
   // R1
   frac_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!tick && !wr_sec && !wr_frac) |=> $stable(frac));

   // R5
   frac_fill_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_frac && !wr_sec) |=> (&frac));

   // R4
   sec_load_chk: assert property (@(posedge clk) disable iff (!por_n)
      wr_sec |=> (frac == '0 && sec == $past(reg_wdata)));

   // R2
   sec_step_chk: assert property (@(posedge clk) disable iff (!por_n)
      (tick && (&frac) && !wr_sec && !wr_frac) |=> (sec == $past(sec) + 1'b1));

   // R10
   lock_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(st) |-> $past(!lock && tick));

   // R11
   en_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(st) |-> $past(en));
endmodule

bind tod_timer tod_timer_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .por_n(por_n), .tick(tick), .wr_sec(wr_sec), .wr_frac(wr_frac),
   .reg_wdata(reg_wdata), .frac(frac), .sec(sec), .lock(lock), .en(en), .st(st)
);

// File: tb/tod_timer_test.sv
module tod_timer_test;
   localparam int CLK_P = 10;
   localparam int DIV   = 128;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        alarm_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // behavioural model state
   int          m_pre;
   logic [7:0]  m_frac, m_snap, m_afrac;
   logic [31:0] m_sec, m_asec;
   bit          m_en, m_st, m_lock;

   tod_timer uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .alarm_flag(alarm_flag)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (!por_n) begin
         m_pre = 0; m_frac = 0; m_sec = 0; m_snap = 0;
         m_afrac = 0; m_asec = 0; m_en = 0; m_st = 0; m_lock = 0;
      end else begin
         bit t, h, clr;
         t = (m_pre == DIV - 1);
         m_pre = (m_pre + 1) % DIV;
         h = t && m_en && !m_lock && (m_sec == m_asec) && (m_frac == m_afrac);
         if (reg_rd && reg_addr == 3'd1) m_snap = m_frac;
         if (reg_wr && reg_addr == 3'd1) begin
            m_sec = reg_wdata; m_frac = 0;
         end else if (reg_wr && reg_addr == 3'd2) begin
            m_frac = 8'hFF;
         end else if (t) begin
            if (m_frac == 8'hFF) m_sec = m_sec + 1;
            m_frac = m_frac + 1;
         end
         if (reg_wr && reg_addr == 3'd3) begin m_asec = reg_wdata; m_lock = 1; end
         if (reg_wr && reg_addr == 3'd4) begin m_afrac = reg_wdata[31:24]; m_lock = 0; end
         if (!rst_n) begin
            m_en = 0; m_st = 0;
         end else begin
            clr = reg_wr && reg_addr == 3'd0 && reg_wdata[1];
            m_st = h || (m_st && !clr);
            if (reg_wr && reg_addr == 3'd0) m_en = reg_wdata[0];
         end
      end
   end

   function automatic logic [31:0] mread(input logic [2:0] a);
      case (a)
         3'd0: return {30'd0, m_st, m_en};
         3'd1: return m_sec;
         3'd2: return {m_snap, 24'd0};
         3'd3: return m_asec;
         3'd4: return {m_afrac, 24'd0};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R8: flag follows the model status on every clock
   always @(negedge clk) begin
      if (por_n && !done) check({31'd0, alarm_flag}, {31'd0, m_st}, "R8 flag per cycle");
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input string tag, output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1;
      v = reg_rdata;
      check(v, mread(a), tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 60000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v1, s0;
      idle(5);
      por_n = 1'b1; rst_n = 1'b1;
      idle(2);

      // R7 power-on state
      rd(3'd0, "R7 ctrl", v);   check(v, 32'd0, "R7 ctrl zero");
      rd(3'd1, "R7 sec", v);    check(v, 32'd0, "R7 sec zero");
      rd(3'd3, "R7 asec", v);   check(v, 32'd0, "R7 asec zero");

      // R4 seconds load clears fraction
      wr(3'd1, 32'h0000_1234);
      rd(3'd1, "R4 sec", v);    check(v, 32'h0000_1234, "R4 sec value");
      rd(3'd2, "R4 frac", v);

      // R1 fraction rate
      wr(3'd1, 32'h10);
      idle(DIV * 10);
      rd(3'd1, "R1 sec", v);
      rd(3'd2, "R1 frac", v);

      // R3 snapshot is held across reads
      idle(DIV * 3 + 7);
      rd(3'd1, "R3 sec", v);
      rd(3'd2, "R3 frac first", v1);
      idle(DIV * 4);
      rd(3'd2, "R3 frac repeat", v);
      check(v, v1, "R3 frac stable");
      check({8'd0, v[23:0]}, 32'd0, "R3 low bits zero");

      // R5 fraction write sets all ones
      wait (m_pre == 5);
      wr(3'd2, 32'h0);
      rd(3'd1, "R5 sec", v);
      rd(3'd2, "R5 frac", v);
      check(v, 32'hFF00_0000, "R5 frac ones");

      // R2 rollover of both counters
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd2, 32'h0);
      idle(DIV * 2);
      rd(3'd1, "R2 sec", v);
      check(v, 32'd0, "R2 sec wrapped");

      // R8 alarm match
      wr(3'd1, 32'd100);
      wr(3'd3, 32'd100);
      wr(3'd4, 32'h0300_0000);
      wr(3'd0, 32'h1);
      idle(DIV * 6);
      check({31'd0, alarm_flag}, 32'd1, "R8 alarm set");
      rd(3'd0, "R8 ctrl", v);   check(v, 32'd3, "R8 ctrl status");

      // R9 write-one-to-clear
      wr(3'd0, 32'h1);
      rd(3'd0, "R9 keep", v);   check(v, 32'd3, "R9 zero leaves status");
      wr(3'd0, 32'h3);
      rd(3'd0, "R9 clear", v);  check(v, 32'd1, "R9 one clears status");

      // R10 lockout after seconds-target write
      wr(3'd1, 32'd200);
      wr(3'd3, 32'd200);
      idle(DIV * 8);
      check({31'd0, alarm_flag}, 32'd0, "R10 locked no alarm");
      wr(3'd1, 32'd200);
      wr(3'd4, 32'h0300_0000);
      idle(DIV * 6);
      check({31'd0, alarm_flag}, 32'd1, "R10 unlocked alarm");

      // R11 disabled compare
      wr(3'd0, 32'h2);
      wr(3'd1, 32'd200);
      idle(DIV * 6);
      check({31'd0, alarm_flag}, 32'd0, "R11 disabled no alarm");
      rd(3'd0, "R11 ctrl", v);  check(v, 32'd0, "R11 ctrl zero");

      // R6 functional reset keeps time and targets
      wr(3'd0, 32'h1);
      rd(3'd1, "R6 sec before", s0);
      @(negedge clk); rst_n = 1'b0;
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      rd(3'd1, "R6 sec after", v);
      check(v, s0, "R6 sec kept");
      rd(3'd3, "R6 asec", v);   check(v, 32'd200, "R6 asec kept");
      rd(3'd4, "R6 afrac", v);  check(v, 32'h0300_0000, "R6 afrac kept");
      rd(3'd0, "R6 ctrl", v);   check(v, 32'd0, "R6 ctrl cleared");

      idle(4);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule